// File: doc/BRIEF.md
# Counter-Polled Bus Arbiter

This block decides which of several bus masters owns a shared bus. The masters all raise one common request, which is formed here as the OR of a per-device request vector. The arbiter waits until some request is present and the bus is not busy. It then steps a poll counter through device addresses, one address per clock, and shows each count on a shared poll-address output. The first polled device that is requesting wins. The counter then freezes on that device's address, and a grant-valid flag with the winner's index is raised.

Priority is not wired in. Each round starts at a start address that software writes through a write-enabled register, so the order of service can be rotated or reordered at run time. The owner keeps the bus for as long as it keeps its request asserted. When it drops the request, the arbiter goes idle, and the next round begins again from the programmed start address. If every request vanishes during a round before any device matches, the round is abandoned and no grant is given.

Top module: `bus_poll_arbiter`

## Requirements
- R1: After reset, grant_vld_o and poll_active_o are 0 and the programmed start address is 0.
- R2: A polling round begins only on a clock edge where at least one bit of req_i is 1 and bus_busy_i is 0. Otherwise the arbiter stays idle, with poll_active_o and grant_vld_o both 0.
- R3: In the first cycle of a round, poll_active_o is 1 and poll_addr_o equals the start address held before the edge that began the round.
- R4: While polling without a match, poll_addr_o increases by one each clock and wraps from N_DEV-1 to 0.
- R5: When the polled device is requesting (req_i[poll_addr_o]=1 while poll_active_o=1), the next cycle shows grant_vld_o=1 with grant_idx_o equal to that address, and poll_active_o=0.
- R6: While granted, the counter is frozen: poll_addr_o equals grant_idx_o and does not change, and poll_active_o is 0.
- R7: The grant holds, regardless of other requests, while req_i[grant_idx_o] stays 1. The cycle after it drops, the arbiter is idle.
- R8: A write (start_wr_i=1, value start_val_i) changes the start address from the next edge on. It does not alter a round already running, and it sets the first address of every later round.
- R9: If req_i becomes all zero during polling, the next cycle is idle and no grant is given.
- R10: bus_busy_i has no effect once a round has begun, whether during polling or during a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_DEV | Per-device bus request, bit i is device address i |
| bus_busy_i | input | 1 | Bus in use, blocks the start of a round |
| start_wr_i | input | 1 | Write enable for the start address |
| start_val_i | input | ADDR_W | Start address to write |
| poll_addr_o | output | ADDR_W | Current poll count driven to all devices |
| poll_active_o | output | 1 | A polling round is in progress |
| grant_vld_o | output | 1 | A device owns the bus |
| grant_idx_o | output | ADDR_W | Address of the owning device |

## Verification
The hardest situations to reach are the ones where timing between events matters. One is a start-address write that lands while a round is already counting. Another is all requests vanishing between two poll steps. A third is a wrap from the top address back to zero with a device count that is not a power of two. The bench builds the block with six devices. It places start writes and request drops at chosen negative edges relative to the round's progress, and a reference model decides on every clock which address should be polled or granted.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE = 2'd0,
      ARB_POLL = 2'd1,
      ARB_OWN  = 2'd2
   } arb_state_e;

endpackage

// File: rtl/poll_start_reg.sv
module poll_start_reg #(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_val,
   output logic [ADDR_W-1:0] start_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         start_q <= '0;
      else if (wr_en)
         start_q <= wr_val;
   end

endmodule

// File: rtl/poll_counter.sv
module poll_counter #(
   parameter int N_DEV  = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] cnt_q
);

   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(N_DEV - 1);
   localparam bit POW2 = ((1 << ADDR_W) == N_DEV);

   logic [ADDR_W-1:0] cnt_inc;

   generate
      if (POW2) begin : g_natural_wrap
         assign cnt_inc = cnt_q + 1'b1;
      end else begin : g_compare_wrap
         assign cnt_inc = (cnt_q == TOP_ADDR) ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (step)
         cnt_q <= cnt_inc;
   end

   // R4: one address per step, wrapping at the top device address
   p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cnt_q == (($past(cnt_q) == TOP_ADDR) ? '0 : $past(cnt_q) + 1'b1)));

   // R6: counter is frozen when neither loading nor stepping
   p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/poll_match.sv
module poll_match #(
   parameter int N_DEV  = 8,
   parameter int ADDR_W = 3
) (
   input  logic [N_DEV-1:0]  req,
   input  logic [ADDR_W-1:0] cnt,
   output logic              any_req,
   output logic              hit
);

   logic [N_DEV-1:0] dev_hit;

   generate
      for (genvar i = 0; i < N_DEV; i++) begin : g_dev
         assign dev_hit[i] = req[i] && (cnt == ADDR_W'(i));
      end
   endgenerate

   assign any_req = |req;
   assign hit     = |dev_hit;

   always_comb begin
      p_single_hit_r5: assert ($onehot0(dev_hit));
   end

endmodule

// File: rtl/bus_poll_arbiter.sv
module bus_poll_arbiter
   import poll_arb_pkg::*;
#(
   parameter int N_DEV  = 8,
   parameter int ADDR_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_DEV-1:0]  req_i,
   input  logic              bus_busy_i,
   input  logic              start_wr_i,
   input  logic [ADDR_W-1:0] start_val_i,
   output logic [ADDR_W-1:0] poll_addr_o,
   output logic              poll_active_o,
   output logic              grant_vld_o,
   output logic [ADDR_W-1:0] grant_idx_o
);

   generate
      if (N_DEV < 2) begin : g_bad_count
         $error("bus_poll_arbiter: N_DEV must be at least 2");
      end
      if ((1 << ADDR_W) < N_DEV) begin : g_bad_width
         $error("bus_poll_arbiter: ADDR_W too narrow for N_DEV");
      end
   endgenerate

   arb_state_e        state_q, state_d;
   logic [ADDR_W-1:0] start_q;
   logic [ADDR_W-1:0] cnt_q;
   logic              any_req, hit;
   logic              cnt_load, cnt_step;

   poll_start_reg #(.ADDR_W(ADDR_W)) start_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (start_wr_i),
      .wr_val  (start_val_i),
      .start_q (start_q)
   );

   poll_counter #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) counter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (start_q),
      .step     (cnt_step),
      .cnt_q    (cnt_q)
   );

   poll_match #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) match_i (
      .req     (req_i),
      .cnt     (cnt_q),
      .any_req (any_req),
      .hit     (hit)
   );

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      cnt_step = 1'b0;
      unique case (state_q)
         ARB_IDLE: begin
            if (any_req && !bus_busy_i) begin
               state_d  = ARB_POLL;
               cnt_load = 1'b1;
            end
         end
         ARB_POLL: begin
            if (!any_req)
               state_d = ARB_IDLE;
            else if (hit)
               state_d = ARB_OWN;
            else
               cnt_step = 1'b1;
         end
         ARB_OWN: begin
            if (!hit)
               state_d = ARB_IDLE;
         end
         default: state_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ARB_IDLE;
      else
         state_q <= state_d;
   end

   assign poll_addr_o   = cnt_q;
   assign poll_active_o = (state_q == ARB_POLL);
   assign grant_vld_o   = (state_q == ARB_OWN);
   assign grant_idx_o   = cnt_q;

   // R2: an idle arbiter with no request or a busy bus stays idle
   p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!poll_active_o && !grant_vld_o && (!any_req || bus_busy_i))
         |=> (!poll_active_o && !grant_vld_o));

   // R3: a round opens on the previously held start address
   p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(poll_active_o) |-> (poll_addr_o == $past(start_q)));

   // R5: a requesting polled device is granted next cycle
   p_grant_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_active_o && req_i[poll_addr_o])
         |=> (grant_vld_o && !poll_active_o && grant_idx_o == $past(poll_addr_o)));

   // R6: grant and polling are exclusive, counter shows the owner
   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld_o |-> (!poll_active_o && poll_addr_o == grant_idx_o));

   // R7: grant held while the owner keeps requesting
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld_o && req_i[grant_idx_o]) |=> (grant_vld_o && $stable(grant_idx_o)));

   // R7: release returns to idle
   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld_o && !req_i[grant_idx_o]) |=> (!grant_vld_o && !poll_active_o));

   // R9: vanished requests abort the round without a grant
   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_active_o && !any_req) |=> (!poll_active_o && !grant_vld_o));

endmodule

// File: tb/bus_poll_arbiter_tb_top.sv
module bus_poll_arbiter_tb_top;

   localparam int N  = 6;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic          busy = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] wval = '0;
   logic [AW-1:0] poll_addr, grant_idx;
   logic          poll_act, grant_vld;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 1'b0;

   // reference model state
   int m_st = 0;      // 0 idle, 1 polling, 2 granted
   int m_cnt = 0;
   int m_start = 0;

   always #5 clk = ~clk;

   bus_poll_arbiter #(.N_DEV(N)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_i         (req),
      .bus_busy_i    (busy),
      .start_wr_i    (wr),
      .start_val_i   (wval),
      .poll_addr_o   (poll_addr),
      .poll_active_o (poll_act),
      .grant_vld_o   (grant_vld),
      .grant_idx_o   (grant_idx)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_start = 0;
      end else begin
         case (m_st)
            0: if (req != 0 && !busy) begin m_st = 1; m_cnt = m_start; end
            1: if (req == 0) m_st = 0;
               else if (req[m_cnt]) m_st = 2;
               else m_cnt = (m_cnt + 1) % N;
            default: if (!req[m_cnt]) m_st = 0;
         endcase
         if (wr) m_start = int'(wval);
      end
   end

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s got=%0d exp=%0d at cycle %0d", tag, got, exp, cycles);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n && !done) begin
         check(m_st == 1 ? "R4 poll_active" : "R2 poll_active", int'(poll_act), int'(m_st == 1));
         check(m_st == 2 ? "R7 grant_vld" : "R5 grant_vld", int'(grant_vld), int'(m_st == 2));
         if (m_st == 1) check("R4 poll_addr", int'(poll_addr), m_cnt);
         if (m_st == 2) check("R6 grant_idx", int'(grant_idx), m_cnt);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      step(2);
      check("R1 grant_vld", int'(grant_vld), 0);
      check("R1 poll_active", int'(poll_act), 0);
      rst_n = 1'b1;
      step(1);

      // R2: request while bus busy does not start a round
      req = 6'b001000; busy = 1'b1;
      step(4);
      check("R2 idle while busy", int'(poll_act | grant_vld), 0);
      busy = 1'b0;
      step(1);
      check("R3 first addr", int'(poll_addr), 0);
      busy = 1'b1;                         // R10: busy ignored from here
      step(4);
      check("R5 grant vld", int'(grant_vld), 1);
      check("R5 grant idx", int'(grant_idx), 3);
      // R7: other requests do not steal the grant
      req = 6'b001011;
      step(3);
      check("R7 hold idx", int'(grant_idx), 3);
      check("R10 busy ignored", int'(grant_vld), 1);
      busy = 1'b0;
      req = 6'b000011;
      step(1);
      check("R7 released", int'(grant_vld | poll_act), 0);
      step(1);
      check("R3 restart addr", int'(poll_addr), 0);
      // R8: write during a running round does not change it
      wr = 1'b1; wval = 3'd4;
      step(1);
      wr = 1'b0;
      check("R8 round unchanged", int'(grant_idx), 0);
      req = 6'b000010;                     // owner 0 drops, dev1 still asks
      step(2);
      check("R8 new start", int'(poll_addr), 4);
      step(1);
      check("R4 step", int'(poll_addr), 5);
      step(1);
      check("R4 wrap", int'(poll_addr), 0);
      step(2);
      check("R5 wrapped grant", int'(grant_idx), 1);
      // R9: requests vanish during polling
      req = '0;
      step(2);
      req = 6'b000001;
      step(1);
      check("R9 polling", int'(poll_act), 1);
      req = '0;
      step(1);
      check("R9 abort", int'(poll_act | grant_vld), 0);
      step(2);
      check("R9 no grant", int'(grant_vld), 0);
      // R8: write in the same cycle a round starts uses the old value
      wr = 1'b1; wval = 3'd2; req = 6'b100000;
      step(1);
      wr = 1'b0;
      check("R8 old value used", int'(poll_addr), 4);
      step(3);
      check("R5 late grant", int'(grant_idx), 5);
      req = '0;
      step(2);
      req = 6'b010000;
      step(1);
      check("R3 written start", int'(poll_addr), 2);
      step(4);
      check("R5 dev4", int'(grant_idx), 4);
      step(2);
      summary();
   end

   initial begin
      wait (cycles > 5000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

endmodule